// File: doc/BRIEF.md
# Sprite Table DMA Engine

This block fills the sprite attribute RAM with a 160-byte block taken from any 256-byte page of a 16-bit system address space. The CPU starts a copy by writing a page number to the trigger register. After a short startup delay, the engine reads one byte from the system bus on a fixed cadence. It writes each byte into the sprite RAM at increasing indices.

While the copy runs, the engine also sits in the CPU's access path. The address space is split into buses by region. A CPU access that lands on the same bus the engine is reading from is redirected: a read is steered to the engine's current source address, and a write is dropped. Sprite RAM is closed to the CPU for the same period: reads are flagged to return 0xFF, and writes are dropped. A model-select input picks between the basic model and the enhanced model. That input changes how work RAM is classified and what the trigger register reads back.

Top module: `spr_copy_dma`

## Requirements
- R1: A trigger write with data V of 0xE0 or below starts a copy from source address V·256 to sprite index 0. A trigger write with V above 0xE0 has no effect: `busy` and any copy in progress stay as they were.
- R2: The first `spr_we` pulse is seen in the cycle after the 10th rising edge that follows the trigger edge. Further pulses follow exactly every 4 cycles.
- R3: The k-th write pulse (k counted from 0) carries `spr_waddr` = k and `mrd_addr` = source + k, with `mrd_en` high. `spr_wdata` equals `mrd_data` in that same cycle.
- R4: An accepted trigger during a copy restarts the copy from the new page at index 0. Arbitration then stays active through the new startup delay, until that copy finishes.
- R5: Bus classes are fixed by address region. 0x0000–0x7FFF and 0xA000–0xBFFF are the main bus, and 0x8000–0x9FFF is the video bus. 0xC000–0xFDFF is the work-RAM bus when `enh_mode`=1 and the main bus when `enh_mode`=0. 0xFE00–0xFFFF is internal.
- R6: The engine is active during a copy once the startup delay (7 cycles) has elapsed, or at any time during a restarted copy. While active, a CPU access whose class equals the class of the current source gets `cpu_addr_eff` = current source address, and `cpu_wr_ok` = 0. When the engine is not active, `cpu_addr_eff` = `cpu_addr` and `cpu_wr_ok` = `cpu_wr`.
- R7: While active, a CPU access to 0xFE00–0xFE9F gives `cpu_rd_ff` = `cpu_rd` and `cpu_wr_ok` = 0. When the engine is not active, `cpu_rd_ff` is 0.
- R8: `busy` rises at the edge that accepts a trigger. It falls at the edge that writes the 160th byte, so exactly 160 write pulses are issued per copy that is not interrupted.
- R9: `trig_rdata` is 0x00 when `enh_mode`=1 and 0xFF when `enh_mode`=0.
- R10: A synchronous reset ends any copy: `busy`, `spr_we` and the restart state are cleared at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| enh_mode | input | 1 | 1 selects the enhanced model |
| trig_wr | input | 1 | CPU write strobe for the trigger register |
| trig_wdata | input | 8 | Page number written to the trigger register |
| trig_rdata | output | 8 | Trigger register readback |
| cpu_addr | input | 16 | CPU access address |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_addr_eff | output | 16 | Address the CPU access is steered to |
| cpu_wr_ok | output | 1 | CPU write may proceed |
| cpu_rd_ff | output | 1 | CPU read must return 0xFF |
| mrd_en | output | 1 | System bus read strobe |
| mrd_addr | output | 16 | System bus read address (current source) |
| mrd_data | input | 8 | System bus read data, valid in the same cycle |
| spr_we | output | 1 | Sprite RAM write strobe |
| spr_waddr | output | 8 | Sprite RAM write index |
| spr_wdata | output | 8 | Sprite RAM write data |
| busy | output | 1 | Copy in progress |

## Verification
The assertions assume that `mrd_data` is valid combinationally in the cycle `mrd_addr` is presented. They also assume that `trig_wr`, the CPU strobes and `enh_mode` change only between clock edges and are held across each edge. The stimulus drives every input shortly after a rising edge and holds it for the whole cycle. The system memory is a combinational function of the read address. Triggers are issued in an idle state, during the startup delay and in the middle of a copy, together with rejected page values. `enh_mode` is toggled while a copy from the 0xE0 page is running, so that page moves between the main and work-RAM classes. CPU addresses are aimed at the source's bus, at sprite RAM and at unrelated regions.

// File: rtl/spr_copy_pkg.sv
package spr_copy_pkg;
   typedef enum logic [1:0] {
      BUS_MAIN = 2'd0,
      BUS_VID  = 2'd1,
      BUS_WRAM = 2'd2,
      BUS_INT  = 2'd3
   } bus_cls_e;
endpackage

// File: rtl/spr_bus_class.sv
module spr_bus_class
   import spr_copy_pkg::*;
#(
   parameter int              ADDR_W       = 16,
   parameter int              HAS_WRAM_BUS = 1,
   parameter logic [ADDR_W-1:0] VID_LO     = 16'h8000,
   parameter logic [ADDR_W-1:0] XRAM_LO    = 16'hA000,
   parameter logic [ADDR_W-1:0] WRAM_LO    = 16'hC000,
   parameter logic [ADDR_W-1:0] INT_LO     = 16'hFE00
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              enh,
   output bus_cls_e          cls
);
   logic wram_sel;

   generate
      if (HAS_WRAM_BUS != 0) begin : g_wram_bus
         assign wram_sel = enh;
      end else begin : g_no_wram_bus
         assign wram_sel = 1'b0;
      end
   endgenerate

   always_comb begin
      if (addr >= INT_LO)
         cls = BUS_INT;
      else if (addr >= WRAM_LO)
         cls = wram_sel ? BUS_WRAM : BUS_MAIN;
      else if (addr >= XRAM_LO)
         cls = BUS_MAIN;
      else if (addr >= VID_LO)
         cls = BUS_VID;
      else
         cls = BUS_MAIN;
   end
endmodule

// File: rtl/spr_copy_seq.sv
module spr_copy_seq #(
   parameter int ADDR_W    = 16,
   parameter int DATA_W    = 8,
   parameter int XFER_LEN  = 160,
   parameter int START_DLY = 7,
   parameter int BYTE_CYC  = 4,
   parameter int MAX_PAGE  = 8'hE0,
   localparam int CNT_W    = $clog2(XFER_LEN + 1),
   localparam int DLY_W    = $clog2(START_DLY + 1),
   localparam int IDX_W    = $clog2(XFER_LEN)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              trig_wr,
   input  logic [DATA_W-1:0] trig_data,
   output logic              busy,
   output logic              active,
   output logic              step,
   output logic [ADDR_W-1:0] src,
   output logic [IDX_W-1:0]  dst
);
   localparam int PAD_W = ADDR_W - DATA_W;

   generate
      if (ADDR_W <= DATA_W) begin : g_bad_width
         $error("spr_copy_seq: ADDR_W must exceed DATA_W");
      end
      if (BYTE_CYC < 1 || XFER_LEN < 2 || START_DLY < 1) begin : g_bad_timing
         $error("spr_copy_seq: BYTE_CYC, XFER_LEN and START_DLY out of range");
      end
   endgenerate

   logic [CNT_W-1:0]  cnt_q;
   logic [DLY_W-1:0]  dly_q;
   logic [ADDR_W-1:0] src_q;
   logic [IDX_W-1:0]  dst_q;
   logic              again_q;
   logic              accept;
   logic              run;
   logic              sub_last;

   assign accept = trig_wr && (trig_data <= DATA_W'(MAX_PAGE));
   assign busy   = (cnt_q != '0);
   assign run    = busy && (dly_q == '0);
   assign step   = run && sub_last;
   assign active = busy && ((dly_q == '0) || again_q);
   assign src    = src_q;
   assign dst    = dst_q;

   generate
      if (BYTE_CYC == 1) begin : g_sub_none
         assign sub_last = 1'b1;
      end else begin : g_sub_cnt
         localparam int SUB_W = $clog2(BYTE_CYC);
         logic [SUB_W-1:0] sub_q;
         always_ff @(posedge clk) begin
            if (rst || accept || !run)
               sub_q <= '0;
            else if (sub_q == SUB_W'(BYTE_CYC - 1))
               sub_q <= '0;
            else
               sub_q <= sub_q + 1'b1;
         end
         assign sub_last = (sub_q == SUB_W'(BYTE_CYC - 1));

         AST_STEP_GAP: assert property (@(posedge clk) disable iff (rst)
            step |=> !step) else $error("byte strobes too close"); // R2
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q   <= '0;
         dly_q   <= '0;
         src_q   <= '0;
         dst_q   <= '0;
         again_q <= 1'b0;
      end else if (accept) begin
         cnt_q   <= CNT_W'(XFER_LEN);
         dly_q   <= DLY_W'(START_DLY);
         src_q   <= {trig_data, {PAD_W{1'b0}}};
         dst_q   <= '0;
         again_q <= busy;
      end else if (busy) begin
         if (dly_q != '0) begin
            dly_q <= dly_q - 1'b1;
         end else if (step) begin
            cnt_q <= cnt_q - 1'b1;
            src_q <= src_q + 1'b1;
            dst_q <= dst_q + 1'b1;
            if (cnt_q == CNT_W'(1))
               again_q <= 1'b0;
         end
      end
   end

   AST_TRIG_START: assert property (@(posedge clk) disable iff (rst)
      accept |=> (busy && !step && dst_q == '0)) else $error("trigger not taken"); // R1
   AST_HIGH_PAGE_IGNORED: assert property (@(posedge clk) disable iff (rst)
      (trig_wr && !accept && !busy) |=> !busy) else $error("rejected page started copy"); // R1
   AST_DST_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
      step |-> (dst_q < IDX_W'(XFER_LEN))) else $error("sprite index overflow"); // R3
   AST_SRC_ADVANCE: assert property (@(posedge clk) disable iff (rst)
      (step && !accept) |=> (src_q == $past(src_q) + 1'b1)) else $error("source not advanced"); // R3
   AST_RESTART_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
      !busy |-> !again_q) else $error("restart flag left set"); // R4
endmodule

// File: rtl/spr_cpu_arb.sv
module spr_cpu_arb
   import spr_copy_pkg::*;
#(
   parameter int              ADDR_W   = 16,
   parameter int              XFER_LEN = 160,
   parameter logic [ADDR_W-1:0] SPR_BASE = 16'hFE00
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              enh,
   input  logic              active,
   input  logic [ADDR_W-1:0] src,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic              cpu_rd,
   input  logic              cpu_wr,
   output logic [ADDR_W-1:0] addr_eff,
   output logic              wr_ok,
   output logic              rd_ff
);
   localparam logic [ADDR_W-1:0] SPR_END = ADDR_W'(SPR_BASE + XFER_LEN);

   bus_cls_e cpu_cls;
   bus_cls_e src_cls;
   logic     clash;
   logic     spr_hit;

   spr_bus_class #(.ADDR_W(ADDR_W)) u_cls_cpu (
      .addr(cpu_addr), .enh(enh), .cls(cpu_cls)
   );
   spr_bus_class #(.ADDR_W(ADDR_W)) u_cls_src (
      .addr(src), .enh(enh), .cls(src_cls)
   );

   assign clash    = active && (cpu_cls == src_cls);
   assign spr_hit  = active && (cpu_addr >= SPR_BASE) && (cpu_addr < SPR_END);
   assign addr_eff = clash ? src : cpu_addr;
   assign wr_ok    = cpu_wr && !clash && !spr_hit;
   assign rd_ff    = cpu_rd && spr_hit;

   AST_FF_NOT_REDIRECTED: assert property (@(posedge clk) disable iff (rst)
      rd_ff |-> (addr_eff == cpu_addr)) else $error("sprite block overlaps redirect"); // R7
endmodule

// File: rtl/spr_copy_dma.sv
module spr_copy_dma #(
   parameter int  ADDR_W    = 16,
   parameter int  DATA_W    = 8,
   parameter int  XFER_LEN  = 160,
   parameter int  START_DLY = 7,
   parameter int  BYTE_CYC  = 4,
   parameter int  MAX_PAGE  = 8'hE0,
   localparam int SPR_AW    = $clog2(XFER_LEN)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              enh_mode,
   input  logic              trig_wr,
   input  logic [DATA_W-1:0] trig_wdata,
   output logic [DATA_W-1:0] trig_rdata,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic              cpu_rd,
   input  logic              cpu_wr,
   output logic [ADDR_W-1:0] cpu_addr_eff,
   output logic              cpu_wr_ok,
   output logic              cpu_rd_ff,
   output logic              mrd_en,
   output logic [ADDR_W-1:0] mrd_addr,
   input  logic [DATA_W-1:0] mrd_data,
   output logic              spr_we,
   output logic [SPR_AW-1:0] spr_waddr,
   output logic [DATA_W-1:0] spr_wdata,
   output logic              busy
);
   logic              active;
   logic              step;
   logic [ADDR_W-1:0] src;

   spr_copy_seq #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .XFER_LEN(XFER_LEN),
      .START_DLY(START_DLY), .BYTE_CYC(BYTE_CYC), .MAX_PAGE(MAX_PAGE)
   ) u_seq (
      .clk(clk), .rst(rst), .trig_wr(trig_wr), .trig_data(trig_wdata),
      .busy(busy), .active(active), .step(step), .src(src), .dst(spr_waddr)
   );

   spr_cpu_arb #(.ADDR_W(ADDR_W), .XFER_LEN(XFER_LEN)) u_arb (
      .clk(clk), .rst(rst), .enh(enh_mode), .active(active), .src(src),
      .cpu_addr(cpu_addr), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
      .addr_eff(cpu_addr_eff), .wr_ok(cpu_wr_ok), .rd_ff(cpu_rd_ff)
   );

   assign mrd_en     = step;
   assign mrd_addr   = src;
   assign spr_we     = step;
   assign spr_wdata  = mrd_data;
   assign trig_rdata = enh_mode ? '0 : '1;

   AST_BUSY_ENDS_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
      ($fell(busy) && !$past(rst)) |-> $past(spr_we)) else $error("busy dropped early"); // R8
   AST_NO_WRITE_IDLE: assert property (@(posedge clk) disable iff (rst)
      !busy |-> !spr_we) else $error("write while idle"); // R8
endmodule

// File: tb/spr_copy_dma_tb.sv
module spr_copy_dma_tb;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        enh_mode = 1'b0;
   logic        trig_wr = 1'b0;
   logic [7:0]  trig_wdata = 8'h00;
   logic [7:0]  trig_rdata;
   logic [15:0] cpu_addr = 16'h0000;
   logic        cpu_rd = 1'b0;
   logic        cpu_wr = 1'b0;
   logic [15:0] cpu_addr_eff;
   logic        cpu_wr_ok;
   logic        cpu_rd_ff;
   logic        mrd_en;
   logic [15:0] mrd_addr;
   logic [7:0]  mrd_data;
   logic        spr_we;
   logic [7:0]  spr_waddr;
   logic [7:0]  spr_wdata;
   logic        busy;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;
   bit done   = 1'b0;

   // reference model state
   int m_start = 0;
   int m_page  = 0;
   bit m_live  = 1'b0;
   bit m_again = 1'b0;

   always #5 clk = ~clk;

   assign mrd_data = mrd_addr[7:0] ^ mrd_addr[15:8] ^ 8'h5A;

   spr_copy_dma u_dut (
      .clk(clk), .rst(rst), .enh_mode(enh_mode), .trig_wr(trig_wr),
      .trig_wdata(trig_wdata), .trig_rdata(trig_rdata), .cpu_addr(cpu_addr),
      .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_addr_eff(cpu_addr_eff),
      .cpu_wr_ok(cpu_wr_ok), .cpu_rd_ff(cpu_rd_ff), .mrd_en(mrd_en),
      .mrd_addr(mrd_addr), .mrd_data(mrd_data), .spr_we(spr_we),
      .spr_waddr(spr_waddr), .spr_wdata(spr_wdata), .busy(busy)
   );

   function automatic int bus_of(input int a, input bit enh);
      if (a >= 'hFE00) return 3;
      if (a >= 'hC000 && enh) return 2;
      if (a >= 'h8000 && a < 'hA000) return 1;
      return 0;
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s at cycle %0d: actual %0h expected %0h", req, cyc, act, exp);
      end
   endtask

   // model advance
   always @(posedge clk) begin
      automatic int e_old = cyc - m_start;
      automatic bit was_busy = m_live && (e_old < 647);
      cyc++;
      if (rst) begin
         m_live = 1'b0; m_again = 1'b0;
      end else if (trig_wr && trig_wdata <= 8'hE0) begin
         m_again = was_busy;
         m_live  = 1'b1;
         m_start = cyc;
         m_page  = trig_wdata;
      end else if (m_live && (cyc - m_start) >= 647) begin
         m_live = 1'b0; m_again = 1'b0;
      end
   end

   // compare every cycle away from the active edge
   always @(negedge clk) begin
      if (!done) begin
         automatic int  e      = cyc - m_start;
         automatic bit  x_busy = m_live;
         automatic bit  x_act  = x_busy && (e >= 7 || m_again);
         automatic bit  x_we   = x_busy && e >= 10 && ((e - 10) % 4) == 0;
         automatic int  k      = (e - 10) / 4;
         automatic int  sidx   = (e < 11) ? 0 : (e - 11) / 4 + 1;
         automatic int  x_src  = m_page * 256 + sidx;
         automatic bit  clash  = x_act && bus_of(int'(cpu_addr), enh_mode) == bus_of(x_src, enh_mode);
         automatic bit  in_spr = x_act && cpu_addr >= 16'hFE00 && cpu_addr < 16'hFEA0;
         automatic int  x_eff  = clash ? x_src : int'(cpu_addr);
         automatic bit  x_wok  = cpu_wr && !clash && !in_spr;
         automatic bit  x_rff  = cpu_rd && in_spr;
         automatic int  x_rb   = enh_mode ? 0 : 'hFF;
         chk(busy == x_busy, "R8/R10 busy", busy, x_busy);
         chk(spr_we == x_we, "R2 write strobe", spr_we, x_we);
         if (x_we) begin
            chk(spr_waddr == k[7:0], "R3 sprite index", spr_waddr, k);
            chk(mrd_addr == x_src[15:0] && mrd_en, "R3 source addr", mrd_addr, x_src);
            chk(spr_wdata == (x_src[7:0] ^ x_src[15:8] ^ 8'h5A), "R3 data", spr_wdata,
                x_src[7:0] ^ x_src[15:8] ^ 8'h5A);
         end
         chk(cpu_addr_eff == x_eff[15:0], "R5/R6 redirect", cpu_addr_eff, x_eff);
         chk(cpu_wr_ok == x_wok, "R6/R7 write gate", cpu_wr_ok, x_wok);
         chk(cpu_rd_ff == x_rff, "R7 sprite read block", cpu_rd_ff, x_rff);
         chk(trig_rdata == x_rb[7:0], "R9 readback", trig_rdata, x_rb);
      end
   end

   task automatic drive_cpu();
      automatic int sel = $urandom % 5;
      case (sel)
         0: cpu_addr = 16'($urandom);
         1: cpu_addr = 16'hFE00 + 16'($urandom % 160);
         2: cpu_addr = 16'h8000 + 16'($urandom % 'h2000);
         3: cpu_addr = 16'hC000 + 16'($urandom % 'h3E00);
         default: cpu_addr = 16'h0000 + 16'($urandom % 'h8000);
      endcase
      cpu_rd = ($urandom % 2) == 1;
      cpu_wr = ($urandom % 2) == 1;
   endtask

   task automatic step(input int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk); #2;
         drive_cpu();
      end
   endtask

   task automatic trig(input logic [7:0] v);
      trig_wr = 1'b1; trig_wdata = v;
      step(1);
      trig_wr = 1'b0;
   endtask

   initial begin
      // R10: reset state observed during reset
      step(3);
      rst = 1'b0;
      step(5);
      trig(8'hE1);            // R1 rejected page
      step(20);
      trig(8'h12);            // R2 R3 R8 main bus source, basic model
      step(700);
      enh_mode = 1'b1;        // R5 R9
      trig(8'hC3);
      step(300);
      trig(8'h85);            // R4 restart from video page mid copy
      step(4);
      trig(8'hA7);            // R4 restart inside startup delay
      step(700);
      trig(8'hE0);            // R1 highest legal page
      step(100);
      enh_mode = 1'b0;        // R5 class of 0xE0xx changes
      step(600);
      trig(8'h40);
      step(200);
      rst = 1'b1;             // R10 reset mid copy
      step(2);
      rst = 1'b0;
      step(20);
      trig(8'h07);
      step(50);
      trig(8'hF0);            // R1 rejected while busy, copy continues
      step(700);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      done = 1'b1;
      $display("FAIL watchdog expired: actual %0d expected %0d", cyc, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule